// File: doc/BRIEF.md
# PLL Reprogramming Sequencer

This block moves a clock synthesizer from one operating point to another. When `start` is pulsed, it captures one operating-point record. The record holds a target rate, the three divider codes, a band value and a bypass flag. The block then builds the new control word and writes it. After the write it counts a fixed lock interval in microsecond ticks. At the end of that interval it samples the lock and error status lines and reports the outcome with a one-cycle completion pulse and a result code.

When the `core_mode` flag is set, the PLL drives the processor core, and a companion interface clock must not run too fast while the core frequency changes. Before a change to a rate above 500 MHz, the block first sets the interface divider to divide-by-2. It returns the divider to divide-by-1 only after a successful relock at 500 MHz or below. The block also decodes its own control register into the frequency it implies for a fixed reference clock.

Top module: `pll_reprog_seq`

## Requirements
- R1: For a record with the bypass flag clear, the written control word is `band<<20 | fb<<9 | id<<4 | od<<2`. Bits 0 (power-down) and 1 (bypass) are zero, and all other bits are zero.
- R2: For a record with the bypass flag set, the written word equals the previous control word with bit 1 set. All other bits are kept.
- R3: After reset the control word is 1 (powered down). Each operation writes the control word exactly once, with a one-cycle `ctrl_we` pulse, and the word changes at no other time.
- R4: Status is sampled in the cycle after the cycle in which the 100th `us_tick` since the control write is consumed. Status values before that point have no effect. `done` follows exactly one cycle after sampling, or two cycles when a restoring divider write is due.
- R5: The result code is 0 for success, 1 when lock is low (whatever the error bit is), and 2 when lock is high and the error bit is high.
- R6: In core mode with a target rate strictly above 500,000,000, the value 1 (divide-by-2) is written to the interface divider once, in the cycle before the control write.
- R7: In core mode with a target at most 500,000,000 and a success result, the value 0 (divide-by-1) is written once, in the `done` cycle. After a timeout or error, no restoring write is made and the divider keeps its last value.
- R8: With `core_mode` low, the interface divider is never written.
- R9: `busy` is high from the cycle after an accepted start until the `done` cycle. A `start` pulse while busy is ignored: it causes no extra write and no extra `done`.
- R10: `eff_rate` equals the reference clock when bit 1 is set. It is 0 when bit 0 is set and bit 1 is clear. Otherwise it equals `REF_HZ*2*(fb+1)/((id+1)*2^od)`, with the fields taken from the current control word.
- R11: `done` is a single-cycle pulse, and `result` is valid while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | active-low reset |
| start | input | 1 | begin an operation (ignored while busy) |
| core_mode | input | 1 | enables interface-divider ordering |
| target_rate | input | RATE_W | target rate in Hz |
| rec_bypass | input | 1 | record selects bypass |
| rec_idiv | input | 5 | input divider code |
| rec_odiv | input | 2 | output divider code |
| rec_fbdiv | input | 7 | feedback divider code |
| rec_band | input | BAND_W | band value |
| stat_lock | input | 1 | PLL lock status |
| stat_err | input | 1 | PLL error status |
| us_tick | input | 1 | one-cycle pulse per microsecond |
| ctrl_word | output | 32 | current control register value |
| ctrl_we | output | 1 | control write strobe |
| ifdiv_val | output | 1 | interface divider (0 = /1, 1 = /2) |
| ifdiv_we | output | 1 | interface divider write strobe |
| done | output | 1 | completion pulse |
| result | output | 2 | 0 success, 1 timeout, 2 error |
| busy | output | 1 | operation in progress |
| eff_rate | output | OUT_W | decoded output frequency in Hz |

## Verification
The bench raises lock exactly one tick-step after the 100th microsecond tick. A sequencer that samples early therefore reports a timeout, and one that samples late misses the exact `done` cycle.

The rate sweep checks that divider ordering treats 500,000,000 as "at or below" and 500,000,001 as "above". An off-by-one comparison would then add or drop a divider write.

The failure cases include a timeout and an error at a low core rate. These catch a design that restores divide-by-1 without first checking for success, and the lock-low/error-high case catches a design that puts error reporting ahead of the timeout.

A bypass record after a normal record must keep every divider field, and a start pulse during the wait must leave the write count at one. Field sweeps over all input, feedback and output codes compare the decoded rate against the bench's arithmetic.

// File: rtl/pll_reprog_seq.sv
module pll_reprog_seq #(
  parameter int          RATE_W    = 32,
  parameter int          BAND_W    = 4,
  parameter int          LOCK_US   = 100,
  parameter int          OUT_W     = 40,
  parameter logic [31:0] THRESH_HZ = 32'd500000000,
  parameter logic [31:0] REF_HZ    = 32'd33333333
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              core_mode,
  input  logic [RATE_W-1:0] target_rate,
  input  logic              rec_bypass,
  input  logic [4:0]        rec_idiv,
  input  logic [1:0]        rec_odiv,
  input  logic [6:0]        rec_fbdiv,
  input  logic [BAND_W-1:0] rec_band,
  input  logic              stat_lock,
  input  logic              stat_err,
  input  logic              us_tick,
  output logic [31:0]       ctrl_word,
  output logic              ctrl_we,
  output logic              ifdiv_val,
  output logic              ifdiv_we,
  output logic              done,
  output logic [1:0]        result,
  output logic              busy,
  output logic [OUT_W-1:0]  eff_rate
);

  localparam int CNT_W = $clog2(LOCK_US + 1);

  typedef enum logic [2:0] {S_IDLE, S_PRE, S_CTRL, S_WAIT, S_CHECK, S_POST} st_t;

  st_t               st;
  logic              core_l, byp_l, above_l;
  logic [4:0]        id_l;
  logic [1:0]        od_l;
  logic [6:0]        fb_l;
  logic [BAND_W-1:0] band_l;
  logic [CNT_W-1:0]  tcnt;
  logic [31:0]       ctrl_q, fresh_w;
  logic              ctrl_we_q, ifdiv_q, ifdiv_we_q, done_q;
  logic [1:0]        res_q;

  always_comb begin
    fresh_w = '0;
    fresh_w[3:2]  = od_l;
    fresh_w[8:4]  = id_l;
    fresh_w[15:9] = fb_l;
    fresh_w[20 +: BAND_W] = band_l;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      core_l <= 1'b0; byp_l <= 1'b0; above_l <= 1'b0;
      id_l <= '0; od_l <= '0; fb_l <= '0; band_l <= '0;
      tcnt <= '0;
      ctrl_q <= 32'h1;
      ctrl_we_q <= 1'b0;
      ifdiv_q <= 1'b0;
      ifdiv_we_q <= 1'b0;
      done_q <= 1'b0;
      res_q <= 2'd0;
    end else begin
      ctrl_we_q  <= 1'b0;
      ifdiv_we_q <= 1'b0;
      done_q     <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          core_l  <= core_mode;
          byp_l   <= rec_bypass;
          above_l <= target_rate > RATE_W'(THRESH_HZ);
          id_l    <= rec_idiv;
          od_l    <= rec_odiv;
          fb_l    <= rec_fbdiv;
          band_l  <= rec_band;
          st <= (core_mode && target_rate > RATE_W'(THRESH_HZ)) ? S_PRE : S_CTRL;
        end
        S_PRE: begin
          ifdiv_q    <= 1'b1;
          ifdiv_we_q <= 1'b1;
          st <= S_CTRL;
        end
        S_CTRL: begin
          ctrl_q    <= byp_l ? (ctrl_q | 32'h2) : fresh_w;
          ctrl_we_q <= 1'b1;
          tcnt <= '0;
          st <= S_WAIT;
        end
        S_WAIT: if (us_tick) begin
          if (tcnt == CNT_W'(LOCK_US - 1)) st <= S_CHECK;
          else tcnt <= tcnt + 1'b1;
        end
        S_CHECK: begin
          if (!stat_lock) begin
            done_q <= 1'b1; res_q <= 2'd1; st <= S_IDLE;
          end else if (stat_err) begin
            done_q <= 1'b1; res_q <= 2'd2; st <= S_IDLE;
          end else if (core_l && !above_l) begin
            st <= S_POST;
          end else begin
            done_q <= 1'b1; res_q <= 2'd0; st <= S_IDLE;
          end
        end
        S_POST: begin
          ifdiv_q    <= 1'b0;
          ifdiv_we_q <= 1'b1;
          done_q     <= 1'b1;
          res_q      <= 2'd0;
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  logic [OUT_W-1:0] num, den;
  assign num = OUT_W'(REF_HZ) * ((OUT_W'(ctrl_q[15:9]) + OUT_W'(1)) << 1);
  assign den = (OUT_W'(ctrl_q[8:4]) + OUT_W'(1)) << ctrl_q[3:2];
  assign eff_rate = ctrl_q[1] ? OUT_W'(REF_HZ) : (ctrl_q[0] ? '0 : num / den);

  assign ctrl_word = ctrl_q;
  assign ctrl_we   = ctrl_we_q;
  assign ifdiv_val = ifdiv_q;
  assign ifdiv_we  = ifdiv_we_q;
  assign done      = done_q;
  assign result    = res_q;
  assign busy      = (st != S_IDLE);

endmodule

// File: rtl/pll_reprog_seq_chk.sv
module pll_reprog_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ctrl_we,
  input logic [31:0] ctrl_word,
  input logic        ifdiv_we,
  input logic        ifdiv_val,
  input logic        done,
  input logic [1:0]  result,
  input logic        busy,
  input logic        core_l
);
  // R3
  ctrl_single_chk: assert property (@(posedge clk) disable iff (!rst_n) ctrl_we |=> !ctrl_we);
  // R3
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) !ctrl_we |-> $stable(ctrl_word));
  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R5
  result_code_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> result != 2'd3);
  // R8
  ifdiv_core_chk: assert property (@(posedge clk) disable iff (!rst_n) ifdiv_we |-> core_l);
  // R6
  pre_order_chk: assert property (@(posedge clk) disable iff (!rst_n) (ifdiv_we && ifdiv_val) |=> ctrl_we);
  // R7
  post_done_chk: assert property (@(posedge clk) disable iff (!rst_n) (ifdiv_we && !ifdiv_val) |-> (done && result == 2'd0));
  // R7
  ifdiv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) !ifdiv_we |-> $stable(ifdiv_val));
  // R9
  idle_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
endmodule

bind pll_reprog_seq pll_reprog_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_word(ctrl_word),
  .ifdiv_we(ifdiv_we), .ifdiv_val(ifdiv_val), .done(done), .result(result),
  .busy(busy), .core_l(core_l)
);

// File: tb/tb_pll_reprog_seq.sv
module tb_pll_reprog_seq;
  localparam longint REF = 33333333;
  localparam longint TH  = 500000000;

  logic clk = 0, rst_n = 0;
  logic start = 0, core_mode = 0, rec_bypass = 0;
  logic [31:0] target_rate = 0;
  logic [4:0] rec_idiv = 0;
  logic [1:0] rec_odiv = 0;
  logic [6:0] rec_fbdiv = 0;
  logic [3:0] rec_band = 0;
  logic stat_lock = 0, stat_err = 0, us_tick = 0;
  logic [31:0] ctrl_word;
  logic ctrl_we, ifdiv_val, ifdiv_we, done, busy;
  logic [1:0] result;
  logic [39:0] eff_rate;

  int checks = 0, errors = 0;
  logic [31:0] m_ctrl = 32'h1;
  logic m_ifd = 1'b0;

  always #5 clk = ~clk;

  pll_reprog_seq dut (
    .clk(clk), .rst_n(rst_n), .start(start), .core_mode(core_mode),
    .target_rate(target_rate), .rec_bypass(rec_bypass), .rec_idiv(rec_idiv),
    .rec_odiv(rec_odiv), .rec_fbdiv(rec_fbdiv), .rec_band(rec_band),
    .stat_lock(stat_lock), .stat_err(stat_err), .us_tick(us_tick),
    .ctrl_word(ctrl_word), .ctrl_we(ctrl_we), .ifdiv_val(ifdiv_val),
    .ifdiv_we(ifdiv_we), .done(done), .result(result), .busy(busy),
    .eff_rate(eff_rate)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint eff_model(input logic [31:0] w);
    if (w[1]) return REF;
    if (w[0]) return 0;
    return (REF * 2 * (longint'(w[15:9]) + 1)) / ((longint'(w[8:4]) + 1) << w[3:2]);
  endfunction

  // mode: 0 lock ok, 1 no lock, 2 lock+err, 3 err without lock
  task automatic run_op(input bit byp, input logic [4:0] id, input logic [1:0] od,
                        input logic [6:0] fb, input logic [3:0] bd, input bit core,
                        input logic [31:0] rate, input int mode, input int tper, input bit poke);
    int n = 0, ctrl_n = 0, ctrl_at = -1, pre_n = 0, post_n = 0, tk = 0, t100 = -1, dl = -1;
    bit seen_ctrl = 0, done_seen = 0, busy_ok = 0;
    logic [31:0] got_w = 0, exp_w;
    logic [1:0] got_res = 0;
    bit exp_pre, exp_post;
    int exp_res;
    exp_w = 32'(bd) << 20 | 32'(fb) << 9 | 32'(id) << 4 | 32'(od) << 2;
    if (byp) exp_w = m_ctrl | 32'h2;
    exp_pre  = core && (longint'(rate) > TH);
    exp_post = core && (longint'(rate) <= TH) && (mode == 0);
    exp_res  = (mode == 3) ? 1 : mode;
    @(negedge clk);
    rec_bypass = byp; rec_idiv = id; rec_odiv = od; rec_fbdiv = fb; rec_band = bd;
    core_mode = core; target_rate = rate; stat_lock = 0; stat_err = (mode == 3);
    us_tick = 0; start = 1;
    while (!done_seen && n < 3000) begin
      @(negedge clk);
      n++;
      start = 0;
      if (n == 1) busy_ok = busy;
      if (ctrl_we) begin ctrl_n++; ctrl_at = n; got_w = ctrl_word; seen_ctrl = 1; end
      if (ifdiv_we) begin
        if (!seen_ctrl && ifdiv_val) pre_n++;
        else if (seen_ctrl && !ifdiv_val) post_n++;
        else pre_n += 10;
      end
      if (done) begin done_seen = 1; dl = n; got_res = result; end
      if (tk >= 100) begin
        stat_lock = (mode == 0 || mode == 2);
        stat_err  = (mode >= 2);
      end
      us_tick = ((n % tper) == 0);
      if (us_tick && seen_ctrl && tk < 100) begin
        tk++;
        if (tk == 100) t100 = n;
      end else if (us_tick && seen_ctrl) tk++;
      if (poke && seen_ctrl && n == ctrl_at + 5) begin
        start = 1; rec_fbdiv = fb ^ 7'h55; rec_bypass = ~byp; core_mode = ~core;
        target_rate = ~rate;
      end
    end
    us_tick = 0;
    chk(done_seen, "R11 done seen", done_seen, 1);
    chk(busy_ok, "R9 busy after start", busy_ok, 1);
    chk(ctrl_n == 1, "R3 one ctrl write", ctrl_n, 1);
    chk(got_w == exp_w, byp ? "R2 bypass word" : "R1 ctrl word", got_w, exp_w);
    chk(dl == t100 + 2 + (exp_post ? 1 : 0), "R4 lock window timing", dl - t100, 2 + (exp_post ? 1 : 0));
    chk(int'(got_res) == exp_res, "R5 result code", got_res, exp_res);
    chk(pre_n == int'(exp_pre), core ? "R6 pre divider write" : "R8 no pre write", pre_n, exp_pre);
    chk(post_n == int'(exp_post), core ? "R7 post divider write" : "R8 no post write", post_n, exp_post);
    m_ctrl = exp_w;
    if (exp_pre) m_ifd = 1'b1;
    if (exp_post) m_ifd = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(!done && !ctrl_we && !ifdiv_we && !busy, "R9 R11 quiet after done",
          {done, ctrl_we, ifdiv_we, busy}, 0);
    end
    chk(ifdiv_val == m_ifd, "R7 divider value", ifdiv_val, m_ifd);
    chk(ctrl_word == m_ctrl, "R3 ctrl held", ctrl_word, m_ctrl);
    chk(longint'(eff_rate) == eff_model(m_ctrl), "R10 effective rate", eff_rate, eff_model(m_ctrl));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(ctrl_word == 32'h1, "R3 reset word", ctrl_word, 1);
    chk(!ctrl_we && !ifdiv_we && !done && !busy, "R11 reset strobes", {ctrl_we, ifdiv_we, done, busy}, 0);
    chk(ifdiv_val == 0, "R7 reset divider", ifdiv_val, 0);
    chk(eff_rate == 0, "R10 powered down rate", eff_rate, 0);
    rst_n = 1;
    run_op(1, 0, 0, 0, 0, 0, 27000000, 0, 3, 0);
    run_op(0, 1, 0, 47, 0, 1, 1600000000, 0, 3, 0);
    run_op(0, 0, 1, 14, 0, 1, 500000000, 0, 3, 0);
    run_op(0, 0, 1, 14, 0, 1, 500000001, 1, 3, 0);
    run_op(0, 1, 2, 39, 5, 1, 400000000, 1, 2, 0);
    run_op(0, 1, 2, 39, 5, 1, 400000000, 2, 2, 0);
    run_op(0, 1, 2, 39, 5, 1, 400000000, 3, 2, 0);
    run_op(0, 1, 2, 35, 0, 1, 300000000, 0, 3, 0);
    run_op(0, 1, 0, 26, 9, 0, 900000000, 0, 2, 0);
    run_op(1, 7, 3, 3, 3, 0, 27000000, 0, 2, 0);
    run_op(0, 0, 1, 20, 2, 1, 700000000, 0, 3, 1);
    run_op(0, 0, 0, 23, 1, 1, 800000000, 2, 1, 1);
    for (int i = 0; i < 32; i++) run_op(0, 5'(i), 1, 10, 4'(i), 0, 100000000, 0, 1, 0);
    for (int i = 0; i < 128; i++) run_op(0, 3, 2, 7'(i), 4'(i), 0, 200000000, 0, 1, 0);
    for (int i = 0; i < 4; i++) run_op(0, 2, 2'(i), 30, 4'hf, 0, 300000000, 0, 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule